// File: doc/BRIEF.md
# Overflow-Checking Lane Shifter with Precision Reduction

This block is the shift stage of a packed-arithmetic datapath. Each operation takes one operand word, a shift amount and a lane width of 8, 16 or 32 bits. Every lane of the word is shifted by the same amount, and each lane is checked for overflow on its own. Left shifts can wrap or saturate. Right shifts can truncate or round. Two narrowing operations are also provided. One turns each signed 16-bit fraction into an unsigned byte, clipping out-of-range values. The other rounds a signed 32-bit word to its upper 16 bits.

The result is registered and appears one cycle after the request, together with a flag for that operation's overflow. Any overflow also sets a sticky flag. That flag keeps its value until it is written through the control write port, which lets software run a whole block of samples and then look at a single bit.

Top module: `dsp_shift_unit`

## Requirements
- R1: For the four shift operations (op_code 0 to 3), an effective shift amount of zero returns every lane unchanged and never reports overflow.
- R2: lane_sel 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 selects one 32-bit lane. The effective shift amount is shamt masked to its low log2(lane width) bits (3, 4 or 5 bits).
- R3: op_code 0 (wrapping left shift) gives each lane shifted left with zeros filled in. A lane with a nonzero amount s overflows when its top s+1 bits are neither all zeros nor all ones.
- R4: op_code 1 (saturating left shift) gives the same result as op_code 0 for a lane that does not overflow. An overflowing lane is replaced by the largest positive value (0x7F, 0x7FFF, 0x7FFFFFFF) when its sign bit was 0, and by the most negative value (0x80, 0x8000, 0x80000000) when its sign bit was 1.
- R5: op_code 2 shifts each lane right arithmetically, copying in the sign bit, and never reports overflow.
- R6: op_code 3 (rounding right shift by s > 0) first shifts the sign-extended lane right by s-1. It then adds 1 and shifts right by one more bit, keeping the lane-width low bits. It never reports overflow.
- R7: op_code 4 reduces each 16-bit halfword h (bit 15 is the sign) to a byte, and the byte for halfword i goes to result bits [8i+7:8i]. A negative h gives 0x00 with overflow. A non-negative h whose bits [14:0] exceed 0x7F80 gives 0xFF with overflow. Otherwise the byte is bits [14:7] of h. The upper half of the result is zero.
- R8: op_code 5 rounds each signed 32-bit word v to 16 bits, placed in result bits [15:0]. A v above 0x7FFF8000 gives 0x7FFF with overflow. Otherwise the result is bits [31:16] of the 33-bit sum v + 0x8000. The upper half of the result is zero.
- R9: In packed mode each lane is processed independently, and res_ovf is the OR of the overflows of all lanes.
- R10: sticky_ovf is cleared by reset. A ctrl_wr cycle loads it with ctrl_flag_wdata, and an overflowing operation in the same cycle still sets it. Nothing else clears it.
- R11: op_valid in one cycle gives res_valid, result and res_ovf after the next clock edge. In cycles without op_valid, res_valid is low and result and res_ovf hold their values. Reset clears all outputs.
- R12: op_code 6 and 7 give a zero result and never report overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation select, 0 to 5 defined |
| lane_sel | input | 2 | Lane width select |
| operand | input | DATA_W | Packed operand word |
| shamt | input | log2(DATA_W) | Shift amount, masked to the lane width |
| ctrl_wr | input | 1 | Load the sticky overflow flag |
| ctrl_flag_wdata | input | 1 | Value loaded into the sticky flag |
| result | output | DATA_W | Registered result |
| res_valid | output | 1 | Result produced by the previous cycle's request |
| res_ovf | output | 1 | Overflow of the last operation |
| sticky_ovf | output | 1 | Sticky overflow flag |

## Verification
The clocked assertions take it for granted that op_valid and ctrl_wr stay low while reset is asserted, so that the first comparison against the past cycle is meaningful. The bench keeps both low until after reset is released. The combinational lane checks assume that op_code, shamt and operand are always driven to known values. The bench drives all inputs from time zero and changes them only on the falling clock edge. Random operands are mixed with small values and sign-boundary values so that both the overflowing and non-overflowing branches of every operation are reached.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;

  typedef enum logic [2:0] {
    OP_SHL      = 3'd0,
    OP_SHL_SAT  = 3'd1,
    OP_SHR      = 3'd2,
    OP_SHR_RND  = 3'd3,
    OP_Q15_U8   = 3'd4,
    OP_RND_HALF = 3'd5
  } shop_e;

  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_16  = 2'd1,
    LW_32  = 2'd2,
    LW_32B = 2'd3
  } lane_w_e;

  function automatic logic is_shift_op(shop_e op);
    return (op == OP_SHL) || (op == OP_SHL_SAT) || (op == OP_SHR) || (op == OP_SHR_RND);
  endfunction

endpackage

// File: rtl/shift_lane.sv
module shift_lane
  import dsp_shift_pkg::*;
#(
  parameter  int W  = 8,
  localparam int SW = $clog2(W)
) (
  input  shop_e           op,
  input  logic [W-1:0]    a,
  input  logic [SW-1:0]   sh,
  output logic [W-1:0]    y,
  output logic            ovf
);

  localparam logic [SW-1:0]  TOP_IDX = SW'(W - 1);
  localparam logic signed [W:0] ONE_X = 1;
  localparam logic [W-1:0]   SAT_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]   SAT_NEG = {1'b1, {(W-1){1'b0}}};

  logic [SW-1:0]       keep_sh;
  logic signed [W-1:0] head;
  logic                mixed;
  logic signed [W:0]   ext;
  logic signed [W:0]   pre;

  always_comb begin
    keep_sh = TOP_IDX - sh;
    head    = $signed(a) >>> keep_sh;
    mixed   = (sh != '0) && (head != '0) && (head != '1);
    ext     = $signed({a[W-1], a});
    pre     = ext >>> (sh - SW'(1));
    y       = '0;
    ovf     = 1'b0;
    case (op)
      OP_SHL: begin
        y   = a << sh;
        ovf = mixed;
      end
      OP_SHL_SAT: begin
        ovf = mixed;
        if (mixed) y = a[W-1] ? SAT_NEG : SAT_POS;
        else       y = a << sh;
      end
      OP_SHR:     y = $signed(a) >>> sh;
      OP_SHR_RND: y = (sh == '0) ? a : W'((pre + ONE_X) >>> 1);
      default: ;
    endcase
  end

  always_comb begin
    if (is_shift_op(op) && (sh == '0))
      assert_zero_shift_R1: assert (y == a && !ovf);
    if ((op == OP_SHL_SAT) && ovf)
      assert_sat_value_R4: assert ((a[W-1] && y == SAT_NEG) || (!a[W-1] && y == SAT_POS));
    if (ovf)
      assert_left_only_R3: assert (op == OP_SHL || op == OP_SHL_SAT);
  end

endmodule

// File: rtl/narrow_unit.sv
module narrow_unit #(
  parameter  int DATA_W = 32,
  localparam int N16    = DATA_W / 16,
  localparam int N32    = DATA_W / 32
) (
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] red_y,
  output logic [N16-1:0]    red_o,
  output logic [DATA_W-1:0] rnd_y,
  output logic [N32-1:0]    rnd_o
);

  assign red_y[DATA_W-1:DATA_W/2] = '0;
  assign rnd_y[DATA_W-1:DATA_W/2] = '0;

  for (genvar h = 0; h < N16; h++) begin : g_red
    logic [15:0] hw;
    logic [7:0]  byte_v;
    logic        clip;
    assign hw = a[16*h +: 16];
    always_comb begin
      if (hw[15]) begin
        byte_v = 8'h00;
        clip   = 1'b1;
      end else if (hw[14:0] > 15'h7F80) begin
        byte_v = 8'hFF;
        clip   = 1'b1;
      end else begin
        byte_v = hw[14:7];
        clip   = 1'b0;
      end
    end
    assign red_y[8*h +: 8] = byte_v;
    assign red_o[h]        = clip;

    always_comb begin
      if (clip)
        assert_reduce_clip_R7: assert (byte_v == 8'h00 || byte_v == 8'hFF);
      if (hw[15])
        assert_reduce_neg_R7: assert (byte_v == 8'h00 && clip);
    end
  end

  for (genvar k = 0; k < N32; k++) begin : g_rnd
    logic [31:0] wd;
    logic [32:0] sum33;
    logic [15:0] up;
    logic        over;
    assign wd = a[32*k +: 32];
    always_comb begin
      over  = $signed(wd) > 32'sh7FFF8000;
      sum33 = {wd[31], wd} + 33'h0_0000_8000;
      up    = over ? 16'h7FFF : 16'(sum33 >> 16);
    end
    assign rnd_y[16*k +: 16] = up;
    assign rnd_o[k]          = over;

    always_comb begin
      if (over)
        assert_round_clip_R8: assert (up == 16'h7FFF);
    end
  end

endmodule

// File: rtl/dsp_shift_unit.sv
module dsp_shift_unit
  import dsp_shift_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int N8     = DATA_W / 8,
  localparam int N16    = DATA_W / 16,
  localparam int N32    = DATA_W / 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [1:0]        lane_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [SH_W-1:0]   shamt,
  input  logic              ctrl_wr,
  input  logic              ctrl_flag_wdata,
  output logic [DATA_W-1:0] result,
  output logic              res_valid,
  output logic              res_ovf,
  output logic              sticky_ovf
);

  shop_e   op;
  lane_w_e lw;
  assign op = shop_e'(op_code);
  assign lw = lane_w_e'(lane_sel);

  logic [DATA_W-1:0] y8, y16, y32;
  logic [N8-1:0]     o8;
  logic [N16-1:0]    o16;
  logic [N32-1:0]    o32;

  for (genvar i = 0; i < N8; i++) begin : g_l8
    shift_lane #(.W(8)) u_lane (
      .op (op), .a (operand[8*i +: 8]), .sh (shamt[$clog2(8)-1:0]),
      .y  (y8[8*i +: 8]), .ovf (o8[i])
    );
  end
  for (genvar i = 0; i < N16; i++) begin : g_l16
    shift_lane #(.W(16)) u_lane (
      .op (op), .a (operand[16*i +: 16]), .sh (shamt[$clog2(16)-1:0]),
      .y  (y16[16*i +: 16]), .ovf (o16[i])
    );
  end
  for (genvar i = 0; i < N32; i++) begin : g_l32
    shift_lane #(.W(32)) u_lane (
      .op (op), .a (operand[32*i +: 32]), .sh (shamt[$clog2(32)-1:0]),
      .y  (y32[32*i +: 32]), .ovf (o32[i])
    );
  end

  logic [DATA_W-1:0] red_y, rnd_y;
  logic [N16-1:0]    red_o;
  logic [N32-1:0]    rnd_o;

  narrow_unit #(.DATA_W(DATA_W)) u_narrow (
    .a (operand), .red_y (red_y), .red_o (red_o), .rnd_y (rnd_y), .rnd_o (rnd_o)
  );

  logic [DATA_W-1:0] grp_y, nxt_y;
  logic              grp_o, nxt_o, flag_nxt;
  logic [DATA_W-1:0] res_q;
  logic              vld_q, ovf_q, flag_q;

  always_comb begin
    case (lw)
      LW_8:    begin grp_y = y8;  grp_o = |o8;  end
      LW_16:   begin grp_y = y16; grp_o = |o16; end
      default: begin grp_y = y32; grp_o = |o32; end
    endcase
    case (op)
      OP_SHL, OP_SHL_SAT, OP_SHR, OP_SHR_RND: begin nxt_y = grp_y; nxt_o = grp_o;  end
      OP_Q15_U8:                              begin nxt_y = red_y; nxt_o = |red_o; end
      OP_RND_HALF:                            begin nxt_y = rnd_y; nxt_o = |rnd_o; end
      default:                                begin nxt_y = '0;    nxt_o = 1'b0;   end
    endcase
    flag_nxt = (ctrl_wr ? ctrl_flag_wdata : flag_q) | (op_valid & nxt_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      vld_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      vld_q  <= op_valid;
      flag_q <= flag_nxt;
      if (op_valid) begin
        res_q <= nxt_y;
        ovf_q <= nxt_o;
      end
    end
  end

  assign result     = res_q;
  assign res_valid  = vld_q;
  assign res_ovf    = ovf_q;
  assign sticky_ovf = flag_q;

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_ovf) |-> $past(ctrl_wr));
  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> sticky_ovf);
  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(result) && $stable(res_ovf)));
  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[2:1] == 2'b11) |=> (result == '0 && !res_ovf));

endmodule

// File: tb/tb_dsp_shift_unit.sv
`timescale 1ns/1ps
module tb_dsp_shift_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [1:0]  lane_sel;
  logic [31:0] operand;
  logic [4:0]  shamt;
  logic        ctrl_wr;
  logic        ctrl_flag_wdata;
  logic [31:0] result;
  logic        res_valid, res_ovf, sticky_ovf;

  int checks = 0;
  int errors = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsp_shift_unit dut (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
    .lane_sel (lane_sel), .operand (operand), .shamt (shamt),
    .ctrl_wr (ctrl_wr), .ctrl_flag_wdata (ctrl_flag_wdata),
    .result (result), .res_valid (res_valid), .res_ovf (res_ovf), .sticky_ovf (sticky_ovf)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [1:0] ws,
                                input logic [31:0] a, input logic [4:0] sh,
                                output logic [31:0] y, output bit o);
    int w;
    longint one = 1;
    y = '0; o = 1'b0;
    w = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    if (op <= 3'd3) begin
      for (int l = 0; l < 32 / w; l++) begin
        longint mask = (one << w) - 1;
        longint x    = (longint'(a) >> (l * w)) & mask;
        longint sx   = (((x >> (w - 1)) & 1) != 0) ? x - (one << w) : x;
        int     s    = int'(sh) & (w - 1);
        longint r    = 0;
        longint t;
        bit     lo   = 1'b0;
        case (op)
          3'd0, 3'd1: begin
            r = (x << s) & mask;
            if (s != 0) begin
              t  = sx >>> (w - 1 - s);
              lo = !(t == 0 || t == -1);
            end
            if (lo && op == 3'd1) r = (sx < 0) ? (one << (w - 1)) : (one << (w - 1)) - 1;
          end
          3'd2: r = (sx >>> s) & mask;
          default: r = (s == 0) ? x : (((sx >>> (s - 1)) + 1) >>> 1) & mask;
        endcase
        y = y | (32'(r) << (l * w));
        o = o | lo;
      end
    end else if (op == 3'd4) begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] hw = a[16*h +: 16];
        logic [7:0]  b;
        if (hw[15]) begin b = 8'h00; o = 1'b1; end
        else if (hw[14:0] > 15'h7F80) begin b = 8'hFF; o = 1'b1; end
        else b = hw[14:7];
        y[8*h +: 8] = b;
      end
    end else if (op == 3'd5) begin
      longint v = longint'($signed(a));
      if (v > 64'sh7FFF8000) begin y[15:0] = 16'h7FFF; o = 1'b1; end
      else y[15:0] = 16'(((v + 64'sh8000) >>> 16) & 64'hFFFF);
    end
  endfunction

  task automatic run_op(string tag, logic [2:0] op, logic [1:0] ws,
                        logic [31:0] a, logic [4:0] sh);
    logic [31:0] ey;
    bit eo;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; lane_sel = ws; operand = a; shamt = sh;
    @(negedge clk);
    op_valid = 1'b0;
    model(op, ws, a, sh, ey, eo);
    exp_flag = exp_flag | eo;
    chk(tag, "result", result, ey);
    chk(tag, "ovf", {31'd0, res_ovf}, {31'd0, eo});
    chk(tag, "valid", {31'd0, res_valid}, 32'd1);
    chk(tag, "sticky", {31'd0, sticky_ovf}, {31'd0, exp_flag});
  endtask

  task automatic dir(string tag, logic [2:0] op, logic [1:0] ws, logic [31:0] a,
                     logic [4:0] sh, logic [31:0] ey, bit eo);
    run_op(tag, op, ws, a, sh);
    chk(tag, "literal result", result, ey);
    chk(tag, "literal ovf", {31'd0, res_ovf}, {31'd0, eo});
  endtask

  task automatic flag_write(bit v);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_flag_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
    exp_flag = v;
    chk("R10 write", "sticky", {31'd0, sticky_ovf}, {31'd0, exp_flag});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; lane_sel = '0; operand = '0;
    shamt = '0; ctrl_wr = 1'b0; ctrl_flag_wdata = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset", "valid", {31'd0, res_valid}, 32'd0);
    chk("R10 reset", "sticky", {31'd0, sticky_ovf}, 32'd0);
    chk("R11 reset", "result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    dir("R1 zero shift left", 3'd0, 2'd2, 32'h8000_0001, 5'd0, 32'h8000_0001, 1'b0);
    dir("R1 zero shift rnd", 3'd3, 2'd1, 32'h8001_7FFF, 5'd16, 32'h8001_7FFF, 1'b0);
    dir("R3 overflow", 3'd0, 2'd2, 32'h4000_0000, 5'd1, 32'h8000_0000, 1'b1);
    dir("R3 no overflow", 3'd0, 2'd2, 32'hC000_0000, 5'd1, 32'h8000_0000, 1'b0);
    flag_write(1'b0);
    dir("R4 saturate", 3'd1, 2'd1, 32'h1234_F000, 5'd4, 32'h7FFF_8000, 1'b1);
    flag_write(1'b0);
    dir("R9 packed bytes", 3'd1, 2'd0, 32'h0102_0304, 5'd2, 32'h0408_0C10, 1'b0);
    dir("R2 amount masked", 3'd1, 2'd0, 32'h0102_0304, 5'd10, 32'h0408_0C10, 1'b0);
    dir("R9 one lane flags", 3'd0, 2'd0, 32'h0140_0101, 5'd1, 32'h0280_0202, 1'b1);
    dir("R5 arithmetic right", 3'd2, 2'd0, 32'h80FF_7F01, 5'd1, 32'hC0FF_3F00, 1'b0);
    dir("R6 rounding right", 3'd3, 2'd2, 32'hFFFF_FFFB, 5'd1, 32'hFFFF_FFFE, 1'b0);
    dir("R6 rounding up", 3'd3, 2'd1, 32'h0003_0006, 5'd2, 32'h0001_0002, 1'b0);
    dir("R7 reduce neg/edge", 3'd4, 2'd0, 32'h7F80_8000, 5'd0, 32'h0000_FF00, 1'b1);
    dir("R7 reduce clip", 3'd4, 2'd0, 32'h7F81_0100, 5'd0, 32'h0000_FF02, 1'b1);
    flag_write(1'b0);
    dir("R7 reduce plain", 3'd4, 2'd0, 32'h4000_0080, 5'd0, 32'h0000_8001, 1'b0);
    dir("R8 round clip", 3'd5, 2'd2, 32'h7FFF_8001, 5'd0, 32'h0000_7FFF, 1'b1);
    dir("R8 round plain", 3'd5, 2'd2, 32'h1234_8000, 5'd0, 32'h0000_1235, 1'b0);
    dir("R8 round negative", 3'd5, 2'd2, 32'hFFFF_7FFF, 5'd0, 32'h0000_FFFF, 1'b0);
    dir("R12 undefined op", 3'd6, 2'd2, 32'hFFFF_FFFF, 5'd3, 32'h0000_0000, 1'b0);
    dir("R12 undefined op7", 3'd7, 2'd0, 32'h8000_8000, 5'd7, 32'h0000_0000, 1'b0);
    chk("R10 sticky kept", "sticky", {31'd0, sticky_ovf}, 32'd1);

    held = result;
    @(negedge clk);
    chk("R11 idle", "valid", {31'd0, res_valid}, 32'd0);
    chk("R11 idle", "result held", result, held);

    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd0; lane_sel = 2'd2; operand = 32'h4000_0000; shamt = 5'd2;
    ctrl_wr = 1'b1; ctrl_flag_wdata = 1'b0;
    @(negedge clk);
    op_valid = 1'b0; ctrl_wr = 1'b0;
    exp_flag = 1'b1;
    chk("R10 write with overflow", "sticky", {31'd0, sticky_ovf}, 32'd1);
    flag_write(1'b0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a = $urandom;
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic [1:0]  ws = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 5))
        0: a = a & 32'h0101_0101;
        1: a = a | 32'hFEFE_FEFE;
        2: a = {1'b0, a[30:0]} >> $urandom_range(0, 20);
        default: ;
      endcase
      run_op("R9 random", op, ws, a, 5'($urandom_range(0, 31)));
      if ($urandom_range(0, 15) == 0) flag_write(1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule